// File: doc/BRIEF.md
# Narrow-to-Wide Memory Write Packer

This block joins a narrow user memory port to a wide native memory port whose data width is a power-of-two multiple of the user width. Narrow writes that land in the same wide word are merged into a holding word, with one enable bit for each narrow lane. The held word goes out as a single wide write in three cases: every lane has been filled, the user pulses flush, or a new narrow write targets a different wide word. A narrow read first drains any held write. The block then forwards the wide address, waits for the wide read data and returns the narrow lane that the low address bits select.

On the narrow side, a command carries its write data in the same beat. The wide side has separate command, write-data and read-data channels, each with a valid/ready handshake. Elaboration stops with an error when the width ratio is not a power-of-two whole number. A ratio of 1 turns every narrow write into a wide write with its single lane enabled.

Top module: `lane_packer`

## Requirements
- R1: A narrow write to address A is placed in lane A mod RATIO of the wide word at address A / RATIO. Lane i occupies wide data bits [i*NW +: NW] and mask bit i, so lane 0 is the least significant.
- R2: When the last empty lane of the held word is written, exactly one wide write is issued for that word with all mask bits set.
- R3: A one-cycle pulse on `u_flush` while a word is held issues a wide write whose mask has only the written lanes set. A flush pulse with nothing held issues no wide command.
- R4: A narrow write whose wide address differs from the held word's address is not accepted at first. The held word is written out with its partial mask, and the new write is then accepted as the first lane of a fresh word.
- R5: Lanes that were skipped within a held word have their mask bit clear and zero data in the wide write.
- R6: A narrow read that arrives while a word is held causes that word's wide write to be issued before the read command goes out on the wide command channel.
- R7: A narrow read issues a wide command with `w_cmd_we` low and the wide address. It returns the selected lane of `w_rdata` on `u_rdata`, and it handles a narrow reader that takes the data in the same cycle it appears or one cycle later. Only one read is in flight at a time.
- R8: `u_cmd_ready` stays low while a wide write is being issued. Wide command and write data keep their valid and value stable until accepted, so no narrow write is lost.
- R9: After reset, `u_cmd_ready` is high and `w_cmd_valid`, `w_wdata_valid` and `u_rdata_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_cmd_valid | input | 1 | Narrow command valid |
| u_cmd_ready | output | 1 | Narrow command accepted |
| u_cmd_we | input | 1 | 1 = write, 0 = read |
| u_cmd_addr | input | AW | Narrow word address |
| u_cmd_wdata | input | NW | Narrow write data, same beat as command |
| u_flush | input | 1 | One-cycle request to write out the held word |
| u_rdata_valid | output | 1 | Narrow read data valid |
| u_rdata_ready | input | 1 | Narrow read data accepted |
| u_rdata | output | NW | Selected narrow lane of read data |
| w_cmd_valid | output | 1 | Wide command valid |
| w_cmd_ready | input | 1 | Wide command accepted |
| w_cmd_we | output | 1 | Wide command is a write |
| w_cmd_addr | output | AW-log2(WW/NW) | Wide word address |
| w_wdata_valid | output | 1 | Wide write data valid |
| w_wdata_ready | input | 1 | Wide write data accepted |
| w_wdata | output | WW | Wide write data |
| w_wdata_mask | output | WW/NW | Per-lane write enable |
| w_rdata_valid | input | 1 | Wide read data valid |
| w_rdata_ready | output | 1 | Wide read data accepted |
| w_rdata | input | WW | Wide read data |

## Verification
`u_cmd_ready` is combinational, so the bench samples it 1 ns after driving a command and counts the write as taken on the next rising edge. A filled word, a flush or an address change shows wide write valid one cycle after the edge that triggers it. A read command appears on the wide side one cycle after it is taken, and `u_rdata` follows `w_rdata` in the same cycle. For these reasons the bench logs wide handshakes at rising edges and reads narrow results at the falling edge just before the edge that accepts them. A sweep over every wide address and every non-empty lane subset is run twice, the second time with wide-side backpressure and a reader that waits one cycle. Every logged wide write is compared with a word built arithmetically from the lanes written.

// File: rtl/lpk_pkg.sv
package lpk_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_WROUT   = 2'd1,
    ST_RDCMD   = 2'd2,
    ST_RDDATA  = 2'd3
  } lpk_state_e;
endpackage

// File: rtl/lpk_rst_sync.sv
module lpk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/lpk_lane_acc.sv
module lpk_lane_acc #(
  parameter int NW    = 8,
  parameter int RATIO = 4,
  parameter int LBW   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [LBW-1:0]      lane,
  input  logic [NW-1:0]       wdata,
  input  logic                clr,
  output logic [NW*RATIO-1:0] acc,
  output logic [RATIO-1:0]    mask
);
  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    logic          hit;
    logic          en;
    logic [NW-1:0] data_d;
    logic [NW-1:0] data_q;
    logic          bit_d;
    logic          bit_q;

    always_comb begin
      hit    = wr_en && (lane == LBW'(g));
      en     = clr || hit;
      data_d = clr ? '0 : wdata;
      bit_d  = !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        bit_q  <= 1'b0;
      end else if (en) begin
        data_q <= data_d;
        bit_q  <= bit_d;
      end
    end

    assign acc[g*NW +: NW] = data_q;
    assign mask[g]         = bit_q;
  end

  // R1
  lane_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mask[$past(lane)]);

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));
endmodule

// File: rtl/lpk_lane_sel.sv
module lpk_lane_sel #(
  parameter int NW    = 8,
  parameter int RATIO = 4,
  parameter int LBW   = 2
) (
  input  logic [NW*RATIO-1:0] wide,
  input  logic [LBW-1:0]      sel,
  output logic [NW-1:0]       narrow
);
  if (RATIO == 1) begin : g_pass
    assign narrow = wide;
  end else begin : g_mux
    logic [NW-1:0] slices [RATIO];
    for (genvar g = 0; g < RATIO; g++) begin : g_slice
      assign slices[g] = wide[g*NW +: NW];
    end
    assign narrow = slices[sel];
  end
endmodule

// File: rtl/lpk_ctrl.sv
module lpk_ctrl
  import lpk_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int LBW   = 2,
  parameter int WAW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             u_cmd_valid,
  input  logic             u_cmd_we,
  input  logic [WAW-1:0]   c_waddr,
  input  logic [LBW-1:0]   c_lane,
  input  logic             u_flush,
  input  logic [RATIO-1:0] mask,
  output logic             u_cmd_ready,
  output logic             acc_wr,
  output logic             acc_clr,
  output logic             w_cmd_valid,
  input  logic             w_cmd_ready,
  output logic             w_cmd_we,
  output logic [WAW-1:0]   w_cmd_addr,
  output logic             w_wdata_valid,
  input  logic             w_wdata_ready,
  input  logic             w_rdata_valid,
  output logic             w_rdata_ready,
  output logic             u_rdata_valid,
  input  logic             u_rdata_ready,
  output logic [LBW-1:0]   sel_lane
);
  lpk_state_e       state_q, state_d;
  logic [WAW-1:0]   addr_q, addr_d;
  logic             addr_en;
  logic [LBW-1:0]   lane_q, lane_d;
  logic             lane_en;
  logic             cdone_q, cdone_d;
  logic             ddone_q, ddone_d;
  logic             pend;
  logic             same;
  logic             cfin;
  logic             dfin;
  logic [RATIO-1:0] lane_bit;
  logic [RATIO-1:0] next_mask;

  always_comb begin
    pend          = |mask;
    same          = (c_waddr == addr_q);
    lane_bit      = RATIO'(1) << c_lane;
    state_d       = state_q;
    addr_d        = addr_q;
    addr_en       = 1'b0;
    lane_d        = lane_q;
    lane_en       = 1'b0;
    cdone_d       = cdone_q;
    ddone_d       = ddone_q;
    u_cmd_ready   = 1'b0;
    acc_wr        = 1'b0;
    acc_clr       = 1'b0;
    w_cmd_valid   = 1'b0;
    w_cmd_we      = 1'b0;
    w_wdata_valid = 1'b0;
    w_rdata_ready = 1'b0;
    u_rdata_valid = 1'b0;
    cfin          = 1'b0;
    dfin          = 1'b0;
    next_mask     = mask;
    unique case (state_q)
      ST_COLLECT: begin
        u_cmd_ready = u_cmd_we ? (!pend || same) : !pend;
        acc_wr      = u_cmd_valid && u_cmd_ready && u_cmd_we;
        next_mask   = mask | (acc_wr ? lane_bit : '0);
        if (acc_wr && !pend) begin
          addr_d  = c_waddr;
          addr_en = 1'b1;
        end
        if (u_cmd_valid && u_cmd_ready && !u_cmd_we) begin
          addr_d  = c_waddr;
          addr_en = 1'b1;
          lane_d  = c_lane;
          lane_en = 1'b1;
          state_d = ST_RDCMD;
        end else if ((&next_mask) || (u_flush && (|next_mask)) ||
                     (u_cmd_valid && !u_cmd_ready)) begin
          state_d = ST_WROUT;
        end
      end
      ST_WROUT: begin
        w_cmd_valid   = !cdone_q;
        w_cmd_we      = 1'b1;
        w_wdata_valid = !ddone_q;
        cfin          = cdone_q || w_cmd_ready;
        dfin          = ddone_q || w_wdata_ready;
        if (cfin && dfin) begin
          acc_clr = 1'b1;
          cdone_d = 1'b0;
          ddone_d = 1'b0;
          state_d = ST_COLLECT;
        end else begin
          cdone_d = cfin;
          ddone_d = dfin;
        end
      end
      ST_RDCMD: begin
        w_cmd_valid = 1'b1;
        if (w_cmd_ready) state_d = ST_RDDATA;
      end
      default: begin
        u_rdata_valid = w_rdata_valid;
        w_rdata_ready = u_rdata_ready;
        if (w_rdata_valid && u_rdata_ready) state_d = ST_COLLECT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      cdone_q <= 1'b0;
      ddone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cdone_q <= cdone_d;
      ddone_q <= ddone_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else if (lane_en) begin
      lane_q <= lane_d;
    end
  end

  assign w_cmd_addr = addr_q;
  assign sel_lane   = lane_q;

  // R8
  wcmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmd_valid && !w_cmd_ready) |=>
      (w_cmd_valid && $stable(w_cmd_addr) && $stable(w_cmd_we)));

  // R8
  no_accept_during_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmd_valid && w_cmd_we) |-> !u_cmd_ready);

  // R7
  rd_one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_rdata_valid |-> !u_cmd_ready);
endmodule

// File: rtl/lane_packer.sv
module lane_packer #(
  parameter  int NW    = 8,
  parameter  int WW    = 32,
  parameter  int AW    = 6,
  localparam int RATIO = WW / NW,
  localparam int LB    = $clog2(RATIO),
  localparam int LBW   = (LB == 0) ? 1 : LB,
  localparam int WAW   = AW - LB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             u_cmd_valid,
  output logic             u_cmd_ready,
  input  logic             u_cmd_we,
  input  logic [AW-1:0]    u_cmd_addr,
  input  logic [NW-1:0]    u_cmd_wdata,
  input  logic             u_flush,
  output logic             u_rdata_valid,
  input  logic             u_rdata_ready,
  output logic [NW-1:0]    u_rdata,
  output logic             w_cmd_valid,
  input  logic             w_cmd_ready,
  output logic             w_cmd_we,
  output logic [WAW-1:0]   w_cmd_addr,
  output logic             w_wdata_valid,
  input  logic             w_wdata_ready,
  output logic [WW-1:0]    w_wdata,
  output logic [RATIO-1:0] w_wdata_mask,
  input  logic             w_rdata_valid,
  output logic             w_rdata_ready,
  input  logic [WW-1:0]    w_rdata
);
  if (((WW % NW) != 0) || ((RATIO & (RATIO - 1)) != 0)) begin : g_bad_ratio
    $error("lane_packer: WW must be a power-of-two whole multiple of NW");
  end

  logic             rst_ln;
  logic [WAW-1:0]   c_waddr;
  logic [LBW-1:0]   c_lane;
  logic             acc_wr;
  logic             acc_clr;
  logic [RATIO-1:0] mask;
  logic [LBW-1:0]   sel_lane;

  if (RATIO == 1) begin : g_r1
    assign c_waddr = u_cmd_addr;
    assign c_lane  = '0;
  end else begin : g_rn
    assign c_waddr = u_cmd_addr[AW-1:LB];
    assign c_lane  = u_cmd_addr[LB-1:0];
  end

  lpk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ln)
  );

  lpk_lane_acc #(.NW(NW), .RATIO(RATIO), .LBW(LBW)) u_acc (
    .clk   (clk),
    .rst_n (rst_ln),
    .wr_en (acc_wr),
    .lane  (c_lane),
    .wdata (u_cmd_wdata),
    .clr   (acc_clr),
    .acc   (w_wdata),
    .mask  (mask)
  );

  lpk_ctrl #(.RATIO(RATIO), .LBW(LBW), .WAW(WAW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_ln),
    .u_cmd_valid   (u_cmd_valid),
    .u_cmd_we      (u_cmd_we),
    .c_waddr       (c_waddr),
    .c_lane        (c_lane),
    .u_flush       (u_flush),
    .mask          (mask),
    .u_cmd_ready   (u_cmd_ready),
    .acc_wr        (acc_wr),
    .acc_clr       (acc_clr),
    .w_cmd_valid   (w_cmd_valid),
    .w_cmd_ready   (w_cmd_ready),
    .w_cmd_we      (w_cmd_we),
    .w_cmd_addr    (w_cmd_addr),
    .w_wdata_valid (w_wdata_valid),
    .w_wdata_ready (w_wdata_ready),
    .w_rdata_valid (w_rdata_valid),
    .w_rdata_ready (w_rdata_ready),
    .u_rdata_valid (u_rdata_valid),
    .u_rdata_ready (u_rdata_ready),
    .sel_lane      (sel_lane)
  );

  lpk_lane_sel #(.NW(NW), .RATIO(RATIO), .LBW(LBW)) u_sel (
    .wide   (w_rdata),
    .sel    (sel_lane),
    .narrow (u_rdata)
  );

  assign w_wdata_mask = mask;

  // R3
  wr_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    w_wdata_valid |-> (|w_wdata_mask));

  // R8
  wdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (w_wdata_valid && !w_wdata_ready) |=>
      (w_wdata_valid && $stable(w_wdata_mask) && $stable(w_wdata)));
endmodule

// File: tb/lane_packer_bench.sv
module lane_packer_bench;
  logic        clk;
  logic        rst_n;
  logic        u_cmd_valid;
  logic        u_cmd_ready;
  logic        u_cmd_we;
  logic [5:0]  u_cmd_addr;
  logic [7:0]  u_cmd_wdata;
  logic        u_flush;
  logic        u_rdata_valid;
  logic        u_rdata_ready;
  logic [7:0]  u_rdata;
  logic        w_cmd_valid;
  logic        w_cmd_ready;
  logic        w_cmd_we;
  logic [3:0]  w_cmd_addr;
  logic        w_wdata_valid;
  logic        w_wdata_ready;
  logic [31:0] w_wdata;
  logic [3:0]  w_wdata_mask;
  logic        w_rdata_valid;
  logic        w_rdata_ready;
  logic [31:0] w_rdata;

  lane_packer #(.NW(8), .WW(32), .AW(6)) u_lane_packer (
    .clk           (clk),
    .rst_n         (rst_n),
    .u_cmd_valid   (u_cmd_valid),
    .u_cmd_ready   (u_cmd_ready),
    .u_cmd_we      (u_cmd_we),
    .u_cmd_addr    (u_cmd_addr),
    .u_cmd_wdata   (u_cmd_wdata),
    .u_flush       (u_flush),
    .u_rdata_valid (u_rdata_valid),
    .u_rdata_ready (u_rdata_ready),
    .u_rdata       (u_rdata),
    .w_cmd_valid   (w_cmd_valid),
    .w_cmd_ready   (w_cmd_ready),
    .w_cmd_we      (w_cmd_we),
    .w_cmd_addr    (w_cmd_addr),
    .w_wdata_valid (w_wdata_valid),
    .w_wdata_ready (w_wdata_ready),
    .w_wdata       (w_wdata),
    .w_wdata_mask  (w_wdata_mask),
    .w_rdata_valid (w_rdata_valid),
    .w_rdata_ready (w_rdata_ready),
    .w_rdata       (w_rdata)
  );

  int nchk;
  int nfail;
  int nexp;
  int nca;
  int ndt;
  int napp;
  bit bp_en;
  bit rd_lat;
  logic [7:0]  lfsr;
  logic [31:0] mem     [0:15];
  logic [31:0] exp_mem [0:15];
  logic [3:0]  xa [0:1023];
  logic [3:0]  xm [0:1023];
  logic [31:0] xd [0:1023];
  logic [3:0]  ca [0:1023];
  logic [3:0]  dm [0:1023];
  logic [31:0] dd [0:1023];
  logic        rq;
  logic [3:0]  raddr;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  // wide-side ready pattern, changed away from the active edge
  always @(negedge clk) begin
    lfsr          = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    w_cmd_ready   = bp_en ? lfsr[0] : 1'b1;
    w_wdata_ready = bp_en ? lfsr[3] : 1'b1;
  end

  // wide memory read responder
  assign w_rdata_valid = rq;
  assign w_rdata       = mem[raddr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq    <= 1'b0;
      raddr <= '0;
    end else begin
      if (w_rdata_valid && w_rdata_ready) rq <= 1'b0;
      if (w_cmd_valid && w_cmd_ready && !w_cmd_we) begin
        rq    <= 1'b1;
        raddr <= w_cmd_addr;
      end
    end
  end

  // wide write monitor and memory update
  always @(posedge clk) begin
    if (rst_n) begin
      if (w_cmd_valid && w_cmd_ready && w_cmd_we) begin
        ca[nca] = w_cmd_addr;
        nca++;
      end
      if (w_wdata_valid && w_wdata_ready) begin
        dd[ndt] = w_wdata;
        dm[ndt] = w_wdata_mask;
        ndt++;
      end
      while (napp < nca && napp < ndt) begin
        chk(napp < nexp, "R3 unexpected wide write", napp, nexp);
        chk(ca[napp] == xa[napp], "R1 R4 wide address", ca[napp], xa[napp]);
        chk(dm[napp] == xm[napp], "R2 R3 R5 lane mask", dm[napp], xm[napp]);
        chk(dd[napp] == xd[napp], "R1 R5 wide data", dd[napp], xd[napp]);
        for (int l = 0; l < 4; l++)
          if (dm[napp][l]) mem[ca[napp]][l*8 +: 8] = dd[napp][l*8 +: 8];
        napp++;
      end
      if (w_cmd_valid && w_cmd_ready && !w_cmd_we)
        chk(napp == nexp, "R6 write drained before read", napp, nexp);
      if (w_cmd_valid && w_cmd_we)
        chk(!u_cmd_ready, "R8 user held off during write-out", u_cmd_ready, 0);
    end
  end

  task automatic push_exp(input logic [3:0] a, input logic [3:0] m, input logic [31:0] d);
    xa[nexp] = a;
    xm[nexp] = m;
    xd[nexp] = d;
    for (int l = 0; l < 4; l++)
      if (m[l]) exp_mem[a][l*8 +: 8] = d[l*8 +: 8];
    nexp++;
  endtask

  task automatic nwrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    u_cmd_valid = 1'b1;
    u_cmd_we    = 1'b1;
    u_cmd_addr  = a;
    u_cmd_wdata = d;
    forever begin
      #1;
      if (u_cmd_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 u_cmd_valid = 1'b0;
  endtask

  task automatic nflush();
    @(negedge clk);
    u_flush = 1'b1;
    @(negedge clk);
    u_flush = 1'b0;
  endtask

  task automatic nread(input logic [5:0] a, output logic [7:0] got);
    @(negedge clk);
    u_cmd_valid = 1'b1;
    u_cmd_we    = 1'b0;
    u_cmd_addr  = a;
    forever begin
      #1;
      if (u_cmd_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 u_cmd_valid = 1'b0;
    u_rdata_ready = (rd_lat == 1'b0);
    forever begin
      @(negedge clk);
      if (u_rdata_valid) break;
    end
    if (rd_lat) begin
      @(negedge clk);
      u_rdata_ready = 1'b1;
      #1;
    end
    got = u_rdata;
    @(posedge clk);
    #1 u_rdata_ready = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (napp == nexp) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R8 act=hung exp=complete");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  got;
    logic [31:0] word;
    logic [7:0]  b;
    nchk = 0; nfail = 0; nexp = 0; nca = 0; ndt = 0; napp = 0;
    bp_en = 1'b0; rd_lat = 1'b0; lfsr = 8'h5d;
    rst_n = 1'b0;
    u_cmd_valid = 1'b0; u_cmd_we = 1'b0; u_cmd_addr = '0; u_cmd_wdata = '0;
    u_flush = 1'b0; u_rdata_ready = 1'b0;
    for (int i = 0; i < 16; i++) begin
      mem[i]     = '0;
      exp_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk(u_cmd_ready == 1'b1, "R9 u_cmd_ready after reset", u_cmd_ready, 1);
    chk(w_cmd_valid == 1'b0, "R9 w_cmd_valid after reset", w_cmd_valid, 0);
    chk(w_wdata_valid == 1'b0, "R9 w_wdata_valid after reset", w_wdata_valid, 0);
    chk(u_rdata_valid == 1'b0, "R9 u_rdata_valid after reset", u_rdata_valid, 0);

    // R3 flush with nothing held
    nflush();
    repeat (3) @(negedge clk);
    chk(nca == 0 && ndt == 0, "R3 empty flush issues nothing", nca + ndt, 0);

    // R4 address change flushes the partial word
    push_exp(4'd0, 4'b0111, 32'h00332211);
    push_exp(4'd1, 4'b1111, 32'h88776655);
    nwrite(6'd0, 8'h11);
    nwrite(6'd1, 8'h22);
    nwrite(6'd2, 8'h33);
    nwrite(6'd4, 8'h55);
    nwrite(6'd5, 8'h66);
    nwrite(6'd6, 8'h77);
    nwrite(6'd7, 8'h88);
    drain();
    chk(napp == 2, "R4 two wide writes after address change", napp, 2);

    // R6 read drains the held word
    push_exp(4'd2, 4'b0001, 32'h0000005a);
    nwrite(6'd8, 8'h5a);
    nread(6'd8, got);
    chk(got == 8'h5a, "R6 read after held write", got, 8'h5a);
    nread(6'd5, got);
    chk(got == 8'h66, "R7 read lane 1 of word 1", got, 8'h66);

    // sweep: every wide address, every non-empty lane subset
    for (int pass = 0; pass < 2; pass++) begin
      bp_en  = (pass == 1);
      rd_lat = (pass == 1);
      for (int wa = 0; wa < 16; wa++) begin
        for (int m = 1; m < 16; m++) begin
          word = '0;
          for (int l = 0; l < 4; l++)
            if (m[l]) word[l*8 +: 8] = 8'((wa * 37 + l * 11 + m * 5 + pass * 91 + 1) & 255);
          push_exp(4'(wa), 4'(m), word);
          for (int l = 0; l < 4; l++)
            if (m[l]) begin
              b = word[l*8 +: 8];
              nwrite(6'(wa * 4 + l), b);
            end
          if (m != 15) nflush();
          for (int l = 0; l < 4; l++) begin
            nread(6'(wa * 4 + l), got);
            chk(got == exp_mem[wa][l*8 +: 8], "R1 R7 lane readback", got, exp_mem[wa][l*8 +: 8]);
          end
        end
      end
    end

    drain();
    chk(napp == nexp, "R2 all expected wide writes seen", napp, nexp);
    summary();
    $finish;
  end
endmodule